// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits on an 8-bit CPU bus with a 16-bit address space and turns each memory cycle into one of three device selects: RAM, ROM or video RAM. It also supplies four physical address bits that extend the CPU address. Each bank is 32K, so the block reaches up to 512K of RAM and 512K of ROM. The physical address seen by a memory device is the four bank bits followed by CPU address bits 14 to 0.

The map is set by one control byte. Software loads it with an I/O write to port 50h, and the byte cannot be read back. The byte picks a RAM bank for the low half of the space, and it can swap ROM out of the upper half for RAM bank 0. It can also place a chosen ROM bank in the low half, and it can enable, disable or move a 4K video window. When the video window is enabled it overrides every other region. Bank bit 1 is not used as written: it is XORed with the ROM-off bit, which keeps the bank scheme that older system software expects. Reset clears the byte, which leaves RAM bank 0 low, ROM bank 0 at 8000h to EFFFh and video at F000h to FFFFh.

Top module: `bank_mapper`

## Requirements
- R1: After reset the control byte is 00h, so addresses 0000h-7FFFh select RAM with bank 0, addresses 8000h-EFFFh select ROM with bank 0, and addresses F000h-FFFFh select video RAM.
- R2: The control byte is loaded from cpu_data when iorq_n and wr_n are both low and cpu_addr[7:0] is 50h; cpu_addr[15:8] is ignored. The new value takes effect on the first clock edge at which the strobes are seen high again. An I/O write to any other low address byte, and an I/O cycle with wr_n high, leave the map unchanged.
- R3: While mreq_n is high, ram_cs, rom_cs and vram_cs are all low. While mreq_n is low, exactly one of them is high.
- R4: Bit 2 of the control byte disables video when it is 1. When video is enabled, bit 4 sets its window: 0 gives F000h-FFFFh and 1 gives 8000h-8FFFh. An address inside the enabled window selects video RAM whatever the other bits hold.
- R5: In the upper half (A15=1), outside the video window, bit 3 = 0 selects ROM and bit 3 = 1 selects RAM. In both cases bank_addr is 0.
- R6: In the lower half, when ROM is not placed there, RAM is selected. Its bank_addr is {bit7, bit6, bit1 XOR bit3, bit0}.
- R7: When bit 5 = 1 and bit 3 = 0, the lower half selects ROM with bank_addr {bit7, bit6, bit1, bit0}. When bit 3 = 1, bit 5 has no effect.
- R8: bank_addr is 0 for video cycles and whenever no select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| iorq_n | input | 1 | Active-low I/O request |
| wr_n | input | 1 | Active-low write strobe |
| mreq_n | input | 1 | Active-low memory request |
| ram_cs | output | 1 | RAM select |
| rom_cs | output | 1 | ROM select |
| vram_cs | output | 1 | Video RAM select |
| bank_addr | output | 4 | Physical address bits A18..A15 |

## Verification
The checks assume that memory and I/O requests never overlap. They also assume that the address and data stay steady while an I/O write to the control port is in progress, and that each write strobe lasts at least one clock. The stimulus keeps within these assumptions: it holds mreq_n high for every I/O write, it holds the port address and data fixed for two clocks of active strobes, and it releases both strobes together before it presents any memory address. After each load the sweep covers every one of the 256 control values and every 4K address region.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

   localparam int CTL_W  = 8;
   localparam int BANK_W = 4;

   // Control byte layout; bit positions are software-visible
   typedef struct packed {
      logic bank3;    // bit 7
      logic bank2;    // bit 6
      logic low_rom;  // bit 5: ROM bank in lower half
      logic vid_alt;  // bit 4: video window at 8000h
      logic rom_off;  // bit 3: RAM replaces ROM up high
      logic vid_off;  // bit 2: video window disabled
      logic bank1;    // bit 1
      logic bank0;    // bit 0
   } mapctl_t;

   // Position of each bank bit inside the control byte, LSB first
   function automatic int bank_pos(int idx);
      case (idx)
         0: return 0;
         1: return 1;
         2: return 6;
         default: return 7;
      endcase
   endfunction

endpackage

// File: rtl/bankmap_ctl_reg.sv
module bankmap_ctl_reg
   import bankmap_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter logic [15:0] PORT_ADDR = 16'h0050,
   parameter logic [15:0] PORT_MASK = 16'h00FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              iorq_n,
   input  logic              wr_n,
   output mapctl_t           ctl
);

   if (DATA_W != CTL_W) begin : g_bad_data_w
      $error("bankmap_ctl_reg: DATA_W must equal the control byte width");
   end

   logic              hit;
   logic              hit_q;
   logic [DATA_W-1:0] pend_q;

   assign hit = !iorq_n && !wr_n &&
                (((cpu_addr ^ PORT_ADDR[ADDR_W-1:0]) & PORT_MASK[ADDR_W-1:0]) == '0);

   // Capture while the write is active, commit when the strobes end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         pend_q <= '0;
         ctl    <= '0;
      end else begin
         hit_q <= hit;
         if (hit) begin
            pend_q <= cpu_data;
         end
         if (hit_q && !hit) begin
            ctl <= mapctl_t'(pend_q);
         end
      end
   end

endmodule

// File: rtl/bankmap_decode.sv
module bankmap_decode
   import bankmap_pkg::*;
#(
   parameter logic [3:0] VWIN_MAIN = 4'hF,
   parameter logic [3:0] VWIN_ALT  = 4'h8
) (
   input  mapctl_t           ctl,
   input  logic [3:0]        top_nib,
   input  logic              mreq_n,
   output logic              ram_cs,
   output logic              rom_cs,
   output logic              vram_cs,
   output logic [BANK_W-1:0] bank_addr
);

   logic [CTL_W-1:0]  raw;
   logic [BANK_W-1:0] ram_bank;
   logic [BANK_W-1:0] rom_bank;
   logic              vid_hit;
   logic              upper;

   assign raw = ctl;

   for (genvar i = 0; i < BANK_W; i++) begin : g_bank
      if (i == 1) begin : g_xor
         assign ram_bank[i] = raw[bank_pos(i)] ^ ctl.rom_off;
      end else begin : g_plain
         assign ram_bank[i] = raw[bank_pos(i)];
      end
      assign rom_bank[i] = raw[bank_pos(i)];
   end

   assign upper   = top_nib[3];
   assign vid_hit = !ctl.vid_off &&
                    (top_nib == (ctl.vid_alt ? VWIN_ALT : VWIN_MAIN));

   always_comb begin
      ram_cs    = 1'b0;
      rom_cs    = 1'b0;
      vram_cs   = 1'b0;
      bank_addr = '0;
      if (!mreq_n) begin
         if (vid_hit) begin
            vram_cs = 1'b1;
         end else if (upper) begin
            ram_cs = ctl.rom_off;
            rom_cs = !ctl.rom_off;
         end else if (ctl.low_rom && !ctl.rom_off) begin
            rom_cs    = 1'b1;
            bank_addr = rom_bank;
         end else begin
            ram_cs    = 1'b1;
            bank_addr = ram_bank;
         end
      end
   end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
   import bankmap_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter logic [15:0] PORT_ADDR = 16'h0050,
   parameter logic [15:0] PORT_MASK = 16'h00FF,
   parameter logic [3:0]  VWIN_MAIN = 4'hF,
   parameter logic [3:0]  VWIN_ALT  = 4'h8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              iorq_n,
   input  logic              wr_n,
   input  logic              mreq_n,
   output logic              ram_cs,
   output logic              rom_cs,
   output logic              vram_cs,
   output logic [BANK_W-1:0] bank_addr
);

   localparam int NIB_LO = ADDR_W - 4;

   if (ADDR_W != 16) begin : g_bad_addr_w
      $error("bank_mapper: ADDR_W must be 16");
   end
   if (VWIN_MAIN[3] != 1'b1 || VWIN_ALT[3] != 1'b1) begin : g_bad_vwin
      $error("bank_mapper: video windows must lie in the upper half");
   end

   mapctl_t ctl_q;

   bankmap_ctl_reg #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PORT_ADDR(PORT_ADDR),
      .PORT_MASK(PORT_MASK)
   ) ctl_reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_addr(cpu_addr),
      .cpu_data(cpu_data),
      .iorq_n  (iorq_n),
      .wr_n    (wr_n),
      .ctl     (ctl_q)
   );

   bankmap_decode #(
      .VWIN_MAIN(VWIN_MAIN),
      .VWIN_ALT (VWIN_ALT)
   ) decode_i (
      .ctl      (ctl_q),
      .top_nib  (cpu_addr[ADDR_W-1:NIB_LO]),
      .mreq_n   (mreq_n),
      .ram_cs   (ram_cs),
      .rom_cs   (rom_cs),
      .vram_cs  (vram_cs),
      .bank_addr(bank_addr)
   );

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] cpu_addr,
   input logic        iorq_n,
   input logic        wr_n,
   input logic        mreq_n,
   input logic [7:0]  ctl,
   input logic        ram_cs,
   input logic        rom_cs,
   input logic        vram_cs,
   input logic [3:0]  bank_addr
);

   logic       wr_now;
   logic       wr_prev;
   logic [3:0] nib;
   logic       in_vid;

   assign wr_now = !iorq_n && !wr_n && (((cpu_addr ^ 16'h0050) & 16'h00FF) == 16'h0000);
   assign nib    = cpu_addr[15:12];
   assign in_vid = !ctl[2] && (ctl[4] ? (nib == 4'h8) : (nib == 4'hF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_prev <= 1'b0;
      else        wr_prev <= wr_now;
   end

   // R2
   ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_prev && !wr_now) |-> $stable(ctl));

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_n |-> ({ram_cs, rom_cs, vram_cs} == 3'b000 && bank_addr == 4'h0));

   // R3
   one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mreq_n |-> ($countones({ram_cs, rom_cs, vram_cs}) == 1));

   // R4
   vid_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && in_vid) |-> (vram_cs && bank_addr == 4'h0));

   // R5
   upper_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && nib[3] && !in_vid) |-> (ram_cs == ctl[3] && bank_addr == 4'h0));

   // R7
   low_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && !nib[3] && ctl[5] && !ctl[3]) |->
      (rom_cs && bank_addr == {ctl[7], ctl[6], ctl[1], ctl[0]}));

   // R6
   low_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n && !nib[3] && !(ctl[5] && !ctl[3])) |->
      (ram_cs && bank_addr == {ctl[7], ctl[6], ctl[1] ^ ctl[3], ctl[0]}));

endmodule

bind bank_mapper bank_mapper_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_addr (cpu_addr),
   .iorq_n   (iorq_n),
   .wr_n     (wr_n),
   .mreq_n   (mreq_n),
   .ctl      (ctl_q),
   .ram_cs   (ram_cs),
   .rom_cs   (rom_cs),
   .vram_cs  (vram_cs),
   .bank_addr(bank_addr)
);

// File: tb/bank_mapper_tb_top.sv
module bank_mapper_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'h00;
   logic        iorq_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        mreq_n = 1'b1;
   logic        ram_cs, rom_cs, vram_cs;
   logic [3:0]  bank_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bank_mapper dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_addr (cpu_addr),
      .cpu_data (cpu_data),
      .iorq_n   (iorq_n),
      .wr_n     (wr_n),
      .mreq_n   (mreq_n),
      .ram_cs   (ram_cs),
      .rom_cs   (rom_cs),
      .vram_cs  (vram_cs),
      .bank_addr(bank_addr)
   );

   // Expected {ram, rom, vid, bank[3:0]} from the requirements
   function automatic logic [6:0] expect_map(logic [7:0] c, logic [3:0] nib, logic mreq);
      logic vid;
      vid = !c[2] && (c[4] ? (nib == 4'h8) : (nib == 4'hF));
      if (mreq)                 return 7'b000_0000;            // R3, R8
      if (vid)                  return 7'b001_0000;            // R4, R8
      if (nib[3])               return c[3] ? 7'b100_0000 : 7'b010_0000; // R5
      if (c[5] && !c[3])        return {3'b010, c[7], c[6], c[1], c[0]}; // R7
      return {3'b100, c[7], c[6], c[1] ^ c[3], c[0]};            // R6
   endfunction

   task automatic probe(string req, logic [7:0] c, logic [15:0] a, logic mreq);
      logic [6:0] got, exp;
      @(negedge clk);
      cpu_addr = a;
      mreq_n   = mreq;
      #1;
      got = {ram_cs, rom_cs, vram_cs, bank_addr};
      exp = expect_map(c, a[15:12], mreq);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s ctl=%02h addr=%04h mreq_n=%0b got=%07b exp=%07b",
                  req, c, a, mreq, got, exp);
      end
   endtask

   task automatic io_cycle(logic [15:0] port, logic [7:0] d, logic wr);
      @(negedge clk);
      mreq_n   = 1'b1;
      cpu_addr = port;
      cpu_data = d;
      iorq_n   = 1'b0;
      wr_n     = !wr;
      @(negedge clk);
      @(negedge clk);
      iorq_n = 1'b1;
      wr_n   = 1'b1;
      @(negedge clk);
   endtask

   task automatic sweep(string req, logic [7:0] c);
      for (int n = 0; n < 16; n++) begin
         probe(req, c, {n[3:0], 12'h5A3}, 1'b0);
      end
      probe("R3_idle", c, 16'h1234, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset map
      sweep("R1", 8'h00);
      probe("R1", 8'h00, 16'h0000, 1'b0);
      probe("R1", 8'h00, 16'hEFFF, 1'b0);
      probe("R1", 8'h00, 16'hF000, 1'b0);
      // R2: upper address byte ignored, write lands
      io_cycle(16'hA550, 8'h2D, 1'b1);
      sweep("R2", 8'h2D);
      // R2: other port and read cycle ignored
      io_cycle(16'h0051, 8'hFF, 1'b1);
      sweep("R2_ignore", 8'h2D);
      io_cycle(16'h0050, 8'hC8, 1'b0);
      sweep("R2_ignore", 8'h2D);
      // R4 R5 R6 R7 R8: every control value
      for (int v = 0; v < 256; v++) begin
         io_cycle({8'(v), 8'h50}, 8'(v), 1'b1);
         sweep("R4_R5_R6_R7_R8", 8'(v));
      end
      // R1: reset again clears the byte
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      sweep("R1_rereset", 8'h00);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule